// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns a data virtual address into a physical address with a small set-associative translation buffer. Every way of every set holds two entries. The match entry holds a page tag, a valid bit and a small usage counter. The translate entry holds a physical page number, a cache-inhibit bit and four access-enable bits: read and write, each for supervisor and for user. A lookup reports a hit, a miss or a page fault, and drives a cache-inhibit flag. No refill happens in hardware. Software loads the entries through a synchronous register port and reads them back through the same port.

A normal request updates the usage counters of the indexed set when it hits. When the response is a miss or a fault, the processor takes the exception itself. A probe request does the same lookup with no side effects: it leaves the counters alone, raises nothing and returns zero when the lookup fails. When translation is switched off, or the MMU is marked absent, the address passes through unchanged and cache-inhibit follows the top address bit.

Top module: `dtlb_xlate`

## Requirements
- R1: When `xlateEn` or `mmuPresent` is low, a request returns `rspPaddr` equal to the request address, with hit, miss and fault all low. A normal request then also loads `rspCi` with the top address bit (address at or above 0x80000000).
- R2: The set index is the `SET_BITS` address bits just above the `PAGE_BITS` page offset. A way hits when its valid bit is set and its stored tag equals the address bits above the set index.
- R3: When more than one way of the set hits, the lowest-numbered way supplies the translation.
- R4: On a hit, `rspPaddr` is the entry's physical page number in bits `ADDR_W-1:PAGE_BITS`, with the request's page-offset bits below it. A normal hit loads `rspCi` from the entry's cache-inhibit bit.
- R5: On a normal hit, `rspFault` is raised when the needed access-enable bit is clear. The bit chosen depends on mode and access: supervisor write needs bit 9, supervisor read bit 8, user write bit 7, user read bit 6.
- R6: A normal request that misses returns `rspMiss` high, `rspPaddr` zero and `rspCi` unchanged, and leaves every entry as it was.
- R7: On a normal hit, every way of the indexed set with a nonzero usage counter is decremented by one. The hit way's counter is then ORed with the number of sets minus one. Ways in other sets are not touched.
- R8: A probe never raises `rspMiss` or `rspFault` and never changes a usage counter. A probe that misses or lacks permission returns `rspPaddr` zero. A probe with translation off returns the request address.
- R9: A probe loads `rspCi` only when `reqThruCache` is high. Otherwise `rspCi` keeps its value.
- R10: Every response arrives exactly one cycle after its request, with `rspValid` high. While `rspValid` is low, hit, miss and fault are low.
- R11: The register port address is {way, set, select}, with select 0 for the match entry and 1 for the translate entry. Match word: valid at bit 0, usage at bit 6 upward, tag at bits `ADDR_W-1:PAGE_BITS+SET_BITS`. Translate word: cache-inhibit at bit 1, access enables at bits 9..6, physical page number at bits `ADDR_W-1:PAGE_BITS`. Reset clears every valid bit, usage counter and tag.
- R12: `geomSetsLog2` reports `SET_BITS` and `geomWaysM1` reports the number of ways minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlateEn | input | 1 | Data translation enabled |
| mmuPresent | input | 1 | MMU implemented |
| supMode | input | 1 | Supervisor mode |
| reqValid | input | 1 | Request strobe |
| reqVaddr | input | ADDR_W | Virtual address |
| reqWrite | input | 1 | Access is a write |
| reqProbe | input | 1 | Side-effect-free lookup |
| reqThruCache | input | 1 | Probe may update cache-inhibit |
| rspValid | output | 1 | Response strobe |
| rspPaddr | output | ADDR_W | Physical address |
| rspHit | output | 1 | Buffer hit |
| rspMiss | output | 1 | Miss exception |
| rspFault | output | 1 | Page fault exception |
| rspCi | output | 1 | Cache-inhibit flag |
| cfgWe | input | 1 | Register port write |
| cfgAddr | input | WAY_W+SET_BITS+1 | {way, set, select} |
| cfgWdata | input | ADDR_W | Write data |
| cfgRdata | output | ADDR_W | Read data (combinational) |
| geomSetsLog2 | output | 3 | log2 of set count |
| geomWaysM1 | output | 2 | Way count minus one |

## Verification
Translation results, all flags and `rspCi` are registered. The bench therefore drives a request on a falling edge and compares all of them at the next falling edge, one rising edge later. Usage counters change at that same rising edge. Register-port reads are combinational, so the bench reads counters back a few time units after setting the address, with no request pending. A write takes effect at the first rising edge after it is driven.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // match word fields
  localparam int MATCH_V_BIT   = 0;
  localparam int MATCH_USE_LSB = 6;
  // translate word fields
  localparam int TR_CI_BIT     = 1;
  localparam int TR_PERM_LSB   = 6;
  // permission vector order {supW, supR, usrW, usrR}
  localparam int PERM_USR_R = 0;
  localparam int PERM_USR_W = 1;
  localparam int PERM_SUP_R = 2;
  localparam int PERM_SUP_W = 3;

  typedef struct packed {
    logic       load;        // response register update
    logic       passThru;    // address out = address in
    logic       xlate;       // address out = translated
    logic       ciLoad;      // update cache-inhibit flag
    logic       ciFromEntry; // source of cache-inhibit
    logic       updUsage;    // age the indexed set
    logic       hit;
    logic       miss;
    logic       fault;
    logic [1:0] hitWay;
  } xlateCtl_t;

endpackage

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
#(
  parameter int WAYS = 2
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqProbe,
  input  logic                  reqThruCache,
  input  logic                  xlateEn,
  input  logic                  mmuPresent,
  input  logic                  supMode,
  input  logic [WAYS-1:0]       wayMatch,
  input  logic [WAYS-1:0][3:0]  wayPerm,
  output xlateCtl_t             ctl
);

  logic       active;
  logic       anyHit;
  logic [1:0] firstWay;
  logic [3:0] selPerm;
  logic       permOk;

  assign active = xlateEn && mmuPresent;
  assign anyHit = |wayMatch;

  // lowest matching way wins
  always_comb begin
    firstWay = '0;
    selPerm  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) begin
        firstWay = 2'(w);
        selPerm  = wayPerm[w];
      end
    end
  end

  always_comb begin
    if (supMode) permOk = reqWrite ? selPerm[PERM_SUP_W] : selPerm[PERM_SUP_R];
    else         permOk = reqWrite ? selPerm[PERM_USR_W] : selPerm[PERM_USR_R];
  end

  always_comb begin
    ctl        = '0;
    ctl.hitWay = firstWay;
    if (reqValid) begin
      ctl.load = 1'b1;
      if (!active) begin
        ctl.passThru = 1'b1;
        ctl.ciLoad   = !reqProbe || reqThruCache;
      end else if (anyHit) begin
        ctl.hit         = 1'b1;
        ctl.ciFromEntry = 1'b1;
        if (!reqProbe) begin
          ctl.xlate    = 1'b1;
          ctl.updUsage = 1'b1;
          ctl.ciLoad   = 1'b1;
          ctl.fault    = !permOk;
        end else if (permOk) begin
          ctl.xlate  = 1'b1;
          ctl.ciLoad = reqThruCache;
        end
      end else begin
        ctl.miss = !reqProbe;
      end
    end
  end

endmodule

// File: rtl/dtlb_dpath.sv
module dtlb_dpath
  import dtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 2,
  parameter int WAYS      = 2,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CFG_AW   = WAY_W + SET_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     reqVaddr,
  input  xlateCtl_t             ctl,
  output logic [WAYS-1:0]       wayMatch,
  output logic [WAYS-1:0][3:0]  wayPerm,
  output logic                  rspValid,
  output logic [ADDR_W-1:0]     rspPaddr,
  output logic                  rspHit,
  output logic                  rspMiss,
  output logic                  rspFault,
  output logic                  rspCi,
  input  logic                  cfgWe,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic [ADDR_W-1:0]     cfgWdata,
  output logic [ADDR_W-1:0]     cfgRdata
);

  localparam int SETS    = 1 << SET_BITS;
  localparam int SIDX_W  = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_LSB = PAGE_BITS + SET_BITS;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int PPN_W   = ADDR_W - PAGE_BITS;
  localparam int USE_W   = (SET_BITS > 0) ? SET_BITS : 1;
  localparam logic [USE_W-1:0] USE_RELOAD = USE_W'(SETS - 1);

  logic [TAG_W-1:0] mTag   [WAYS][SETS];
  logic             mValid [WAYS][SETS];
  logic [USE_W-1:0] mUse   [WAYS][SETS];
  logic [PPN_W-1:0] tPpn   [WAYS][SETS];
  logic             tCi    [WAYS][SETS];
  logic [3:0]       tPerm  [WAYS][SETS];

  logic [SIDX_W-1:0] setIdx;
  logic [SIDX_W-1:0] cfgSet;
  logic [WAY_W-1:0]  cfgWay;
  logic              cfgSel;
  logic              cfgWayOk;
  logic [PPN_W-1:0]  hitPpn;
  logic              hitCi;

  generate
    if (SET_BITS > 0) begin : g_setIdx
      assign setIdx = reqVaddr[PAGE_BITS +: SET_BITS];
      assign cfgSet = cfgAddr[SET_BITS:1];
    end else begin : g_noSet
      assign setIdx = '0;
      assign cfgSet = '0;
    end
  endgenerate

  assign cfgSel   = cfgAddr[0];
  assign cfgWay   = cfgAddr[CFG_AW-1 -: WAY_W];
  assign cfgWayOk = (int'(cfgWay) < WAYS);

  // tag compare per way
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign wayMatch[w] = mValid[w][setIdx] &&
                           (mTag[w][setIdx] == reqVaddr[ADDR_W-1:TAG_LSB]);
      assign wayPerm[w]  = tPerm[w][setIdx];
    end
  endgenerate

  always_comb begin
    hitPpn = '0;
    hitCi  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (ctl.hitWay == 2'(w)) begin
        hitPpn = tPpn[w][setIdx];
        hitCi  = tCi[w][setIdx];
      end
    end
  end

  // match array: reset, aging, register writes (write wins)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          mValid[w][s] <= 1'b0;
          mUse[w][s]   <= '0;
          mTag[w][s]   <= '0;
        end
      end
    end else begin
      if (ctl.updUsage) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ctl.hitWay == 2'(w))
            mUse[w][setIdx] <= (mUse[w][setIdx] - USE_W'(mUse[w][setIdx] != '0)) | USE_RELOAD;
          else
            mUse[w][setIdx] <= mUse[w][setIdx] - USE_W'(mUse[w][setIdx] != '0);
        end
      end
      if (cfgWe && cfgWayOk && !cfgSel) begin
        mValid[cfgWay][cfgSet] <= cfgWdata[MATCH_V_BIT];
        mUse[cfgWay][cfgSet]   <= cfgWdata[MATCH_USE_LSB +: USE_W];
        mTag[cfgWay][cfgSet]   <= cfgWdata[ADDR_W-1:TAG_LSB];
      end
    end
  end

  // translate array: written only by software
  always_ff @(posedge clk) begin
    if (cfgWe && cfgWayOk && cfgSel) begin
      tPpn[cfgWay][cfgSet]  <= cfgWdata[ADDR_W-1:PAGE_BITS];
      tCi[cfgWay][cfgSet]   <= cfgWdata[TR_CI_BIT];
      tPerm[cfgWay][cfgSet] <= cfgWdata[TR_PERM_LSB +: 4];
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (cfgWayOk) begin
      if (cfgSel) begin
        cfgRdata[ADDR_W-1:PAGE_BITS]   = tPpn[cfgWay][cfgSet];
        cfgRdata[TR_CI_BIT]            = tCi[cfgWay][cfgSet];
        cfgRdata[TR_PERM_LSB +: 4]     = tPerm[cfgWay][cfgSet];
      end else begin
        cfgRdata[ADDR_W-1:TAG_LSB]     = mTag[cfgWay][cfgSet];
        cfgRdata[MATCH_USE_LSB +: USE_W] = mUse[cfgWay][cfgSet];
        cfgRdata[MATCH_V_BIT]          = mValid[cfgWay][cfgSet];
      end
    end
  end

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
      rspCi    <= 1'b0;
    end else begin
      rspValid <= ctl.load;
      rspHit   <= ctl.load && ctl.hit;
      rspMiss  <= ctl.load && ctl.miss;
      rspFault <= ctl.load && ctl.fault;
      if (ctl.load) begin
        if (ctl.passThru)   rspPaddr <= reqVaddr;
        else if (ctl.xlate) rspPaddr <= {hitPpn, reqVaddr[PAGE_BITS-1:0]};
        else                rspPaddr <= '0;
      end
      if (ctl.ciLoad)
        rspCi <= ctl.ciFromEntry ? hitCi : reqVaddr[ADDR_W-1];
    end
  end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 2,
  parameter int WAYS      = 2,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CFG_AW   = WAY_W + SET_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlateEn,
  input  logic              mmuPresent,
  input  logic              supMode,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqProbe,
  input  logic              reqThruCache,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspCi,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  output logic [2:0]        geomSetsLog2,
  output logic [1:0]        geomWaysM1
);

  xlateCtl_t            ctl;
  logic [WAYS-1:0]      wayMatch;
  logic [WAYS-1:0][3:0] wayPerm;

  assign geomSetsLog2 = 3'(SET_BITS);
  assign geomWaysM1   = 2'(WAYS - 1);

  dtlb_ctrl #(.WAYS(WAYS)) u_ctrl (
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqProbe     (reqProbe),
    .reqThruCache (reqThruCache),
    .xlateEn      (xlateEn),
    .mmuPresent   (mmuPresent),
    .supMode      (supMode),
    .wayMatch     (wayMatch),
    .wayPerm      (wayPerm),
    .ctl          (ctl)
  );

  dtlb_dpath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS), .WAYS(WAYS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .reqVaddr (reqVaddr),
    .ctl      (ctl),
    .wayMatch (wayMatch),
    .wayPerm  (wayPerm),
    .rspValid (rspValid),
    .rspPaddr (rspPaddr),
    .rspHit   (rspHit),
    .rspMiss  (rspMiss),
    .rspFault (rspFault),
    .rspCi    (rspCi),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata)
  );

endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              xlateEn,
  input logic              mmuPresent,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              reqProbe,
  input logic              reqThruCache,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspHit,
  input logic              rspMiss,
  input logic              rspFault,
  input logic              rspCi
);

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && !rspMiss && !rspFault)); // R10

  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (!rspHit && !rspFault && rspPaddr == '0)); // R6

  AST_PROBE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqProbe)) |-> (!rspMiss && !rspFault)); // R8

  AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(xlateEn && mmuPresent)) |->
      (rspPaddr == $past(reqVaddr) && !rspHit)); // R1

  AST_PROBE_CI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqProbe && !reqThruCache)) |-> $stable(rspCi)); // R9

endmodule

bind dtlb_xlate dtlb_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .mmuPresent(mmuPresent),
  .reqValid(reqValid), .reqVaddr(reqVaddr), .reqProbe(reqProbe),
  .reqThruCache(reqThruCache), .rspValid(rspValid), .rspPaddr(rspPaddr),
  .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault), .rspCi(rspCi)
);

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;

  localparam int CLK_P = 10;
  // default geometry: 32-bit address, 8 KiB page, 4 sets, 2 ways
  localparam int NW = 2;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xlateEn = 1'b0, mmuPresent = 1'b0, supMode = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqProbe = 1'b0, reqThruCache = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        rspValid, rspHit, rspMiss, rspFault, rspCi;
  logic [31:0] rspPaddr;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [2:0]  geomSetsLog2;
  logic [1:0]  geomWaysM1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dtlb_xlate uut (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .mmuPresent(mmuPresent),
    .supMode(supMode), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqProbe(reqProbe), .reqThruCache(reqThruCache),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspFault(rspFault), .rspCi(rspCi),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .geomSetsLog2(geomSetsLog2), .geomWaysM1(geomWaysM1)
  );

  // reference model
  logic [16:0] bTag  [NW][NS];
  logic        bV    [NW][NS];
  logic [1:0]  bUse  [NW][NS];
  logic [18:0] bPpn  [NW][NS];
  logic        bCi   [NW][NS];
  logic [3:0]  bPerm [NW][NS];
  logic        ciModel = 1'b0;

  function automatic logic [31:0] matchWord(int w, int s);
    return {bTag[w][s], 15'b0} | (32'(bUse[w][s]) << 6) | 32'(bV[w][s]);
  endfunction

  function automatic logic [31:0] trWord(int w, int s);
    return {bPpn[w][s], 13'b0} | (32'(bPerm[w][s]) << 6) | (32'(bCi[w][s]) << 1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int w, input int s, input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = {w[0], s[1:0], sel}; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!sel) begin
      bV[w][s] = d[0]; bUse[w][s] = d[7:6]; bTag[w][s] = d[31:15];
    end else begin
      bCi[w][s] = d[1]; bPerm[w][s] = d[9:6]; bPpn[w][s] = d[31:13];
    end
  endtask

  task automatic cfgCheck(input string req, input int w, input int s, input bit sel);
    @(negedge clk);
    cfgAddr = {w[0], s[1:0], sel};
    #1;
    chk(req, 64'(cfgRdata), 64'(sel ? trWord(w, s) : matchWord(w, s)));
  endtask

  // one request; expected values from the requirements
  task automatic request(input string req, input logic [31:0] va, input bit wr,
                         input bit pr, input bit th, input bit en, input bit pres,
                         input bit sup);
    int s, hw;
    bit active, perm;
    logic [31:0] ePa;
    bit eHit, eMiss, eFault;
    logic [3:0] p;
    s = int'(va[14:13]);
    hw = -1;
    for (int w = NW - 1; w >= 0; w--)
      if (bV[w][s] && bTag[w][s] == va[31:15]) hw = w;
    active = en && pres;
    ePa = '0; eHit = 0; eMiss = 0; eFault = 0;
    if (!active) begin
      ePa = va;
      if (!pr || th) ciModel = va[31];
    end else if (hw >= 0) begin
      eHit = 1;
      p = bPerm[hw][s];
      perm = sup ? (wr ? p[3] : p[2]) : (wr ? p[1] : p[0]);
      if (!pr) begin
        ePa = {bPpn[hw][s], va[12:0]};
        eFault = !perm;
        ciModel = bCi[hw][s];
      end else if (perm) begin
        ePa = {bPpn[hw][s], va[12:0]};
        if (th) ciModel = bCi[hw][s];
      end
    end else begin
      eMiss = !pr;
    end
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqProbe = pr; reqThruCache = th;
    xlateEn = en; mmuPresent = pres; supMode = sup; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(req, {27'b0, rspValid, rspHit, rspMiss, rspFault, rspCi, rspPaddr},
             {27'b0, 1'b1, eHit, eMiss, eFault, ciModel, ePa});
    if (active && hw >= 0 && !pr) begin
      for (int w = 0; w < NW; w++) begin
        if (bUse[hw][s] == bUse[hw][s]) begin end
        bUse[w][s] = (bUse[w][s] != 0) ? bUse[w][s] - 2'd1 : 2'd0;
      end
      bUse[hw][s] = bUse[hw][s] | 2'd3;
    end
  endtask

  function automatic logic [31:0] va(input logic [16:0] tag, input int s, input logic [12:0] off);
    return {tag, s[1:0], off};
  endfunction

  logic [16:0] tagPool [4];

  initial begin
    tagPool[0] = 17'h00012; tagPool[1] = 17'h10034;
    tagPool[2] = 17'h0ABCD; tagPool[3] = 17'h1FFFF;
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin
        bV[w][s] = 0; bUse[w][s] = 0; bTag[w][s] = 0;
        bPpn[w][s] = 0; bCi[w][s] = 0; bPerm[w][s] = 0;
      end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: no response after reset; R12 geometry
    chk("R10", 64'({rspValid, rspHit, rspMiss, rspFault}), 64'd0);
    chk("R12", 64'({geomSetsLog2, geomWaysM1}), 64'({3'd2, 2'd1}));
    // R11: reset clears match entries
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) cfgCheck("R11", w, s, 0);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) cfgWrite(w, s, 1, {19'(w * 16 + s), 13'h0});

    // R1: bypass cases
    request("R1", 32'h8000_1234, 0, 0, 0, 0, 1, 1);
    request("R1", 32'h0000_1234, 1, 0, 0, 1, 0, 0);
    request("R1", 32'h9000_0040, 0, 0, 0, 0, 0, 0);

    // R11 + R4: load an entry and hit it
    cfgWrite(0, 1, 0, {tagPool[0], 15'b0} | 32'h1);
    cfgWrite(0, 1, 1, {19'h5A5A5, 13'b0} | (32'hF << 6) | 32'h2);
    cfgCheck("R11", 0, 1, 0);
    cfgCheck("R11", 0, 1, 1);
    request("R4", va(tagPool[0], 1, 13'h1ABC), 0, 0, 0, 1, 1, 1);
    request("R2", va(tagPool[0], 2, 13'h0010), 0, 0, 0, 1, 1, 1);
    cfgCheck("R7", 0, 1, 0);

    // R3: two ways match, lowest wins; then only way 1
    cfgWrite(1, 1, 0, {tagPool[0], 15'b0} | (32'h1 << 6) | 32'h1);
    cfgWrite(1, 1, 1, {19'h00777, 13'b0} | (32'hF << 6));
    request("R3", va(tagPool[0], 1, 13'h0004), 1, 0, 0, 1, 1, 0);
    cfgCheck("R7", 0, 1, 0);
    cfgCheck("R7", 1, 1, 0);
    cfgWrite(0, 1, 0, {tagPool[0], 15'b0});
    request("R3", va(tagPool[0], 1, 13'h0008), 0, 0, 0, 1, 1, 0);

    // R5: each single permission bit against each mode/access
    for (int b = 0; b < 4; b++) begin
      cfgWrite(1, 1, 1, {19'h00777, 13'b0} | (32'(1 << b) << 6));
      for (int m = 0; m < 4; m++)
        request("R5", va(tagPool[0], 1, 13'h0100), m[0], 0, 0, 1, 1, m[1]);
    end

    // R6: miss leaves state unchanged
    request("R6", va(tagPool[3], 1, 13'h0002), 0, 0, 0, 1, 1, 1);
    cfgCheck("R6", 1, 1, 0);

    // R8/R9: probe hit w/o thru, probe fault, probe miss, probe bypass
    cfgWrite(1, 1, 1, {19'h00777, 13'b0} | (32'h4 << 6) | 32'h2);
    request("R9", va(tagPool[0], 1, 13'h0003), 0, 1, 0, 1, 1, 1);
    request("R8", va(tagPool[0], 1, 13'h0003), 1, 1, 1, 1, 1, 1);
    request("R8", va(tagPool[2], 3, 13'h0003), 0, 1, 1, 1, 1, 1);
    request("R8", 32'h8123_4567, 0, 1, 0, 0, 1, 1);
    request("R9", va(tagPool[0], 1, 13'h0003), 0, 1, 1, 1, 1, 1);
    cfgCheck("R8", 1, 1, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 15);
      int w = $urandom_range(0, NW - 1);
      int s = $urandom_range(0, NS - 1);
      if (sel == 0) begin
        cfgWrite(w, s, 0, {tagPool[$urandom_range(0, 3)], 15'b0} |
                 (32'($urandom_range(0, 3)) << 6) | 32'($urandom_range(0, 1)));
      end else if (sel == 1) begin
        cfgWrite(w, s, 1, $urandom());
      end else if (sel == 2) begin
        cfgCheck("R7", w, s, 0);
      end else begin
        logic [31:0] a = va(tagPool[$urandom_range(0, 3)], s, 13'($urandom()));
        bit en = ($urandom_range(0, 7) != 0);
        bit pres = ($urandom_range(0, 7) != 0);
        bit pr = ($urandom_range(0, 3) == 0);
        request(pr ? "R8" : "R4", a, 1'($urandom()), pr, 1'($urandom()),
                en, pres, 1'($urandom()));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule